// File: doc/BRIEF.md
# Synchronous SRAM Read Output Pipeline

This block forms the read-data and bus-drive end of a synchronous burst SRAM. Each cycle it receives the command held in the input register (read, write or deselect) together with the word that the array returns for that command. It drives a modelled tri-state data bus as a data vector plus a drive-enable bit. Two configuration straps choose its behaviour. The latency strap either passes array data straight through or inserts a rising-edge output register. The release strap lets the bus turn off right after a deselect, or keeps the final beat on the bus for one extra cycle. A burst therefore shows a first-beat latency of 2-1-1-1 cycles in bypass mode and 3-1-1-1 in registered mode, counted from address capture.

The straps are sampled while reset is held and do not change during operation. The active-low output enable acts asynchronously on the drive, with no clock involved. A cycle that carries a write never drives the bus. A write that follows a read therefore cuts off the stale read word as soon as the read's beat has finished.

The state machine tracks whether the previous output slot carried a read. Its states are ST_QUIET (no read in the previous slot) and ST_BURST (the previous slot was a read). A read slot moves it to ST_BURST, and any other slot moves it to ST_QUIET. The output process turns this into three phases: PH_OFF (bus released), PH_DRIVE (current read word driven) and PH_HOLD (last read word held for one extra slot in the delayed-release mode).

Top module: `sram_out_pipe`

## Requirements
- R1: `strap_pipe_i` and `strap_dual_i` are sampled on every rising edge while `rst_n_i` is low. Changes to them after reset is released have no effect on the bus.
- R2: With the latency strap at 0 (bypass), a read command (`cmd_i` = 2'b01) puts `rdata_i` of the same cycle on `dq_o` with `dq_oe_o` high, provided `oe_n_i` is low.
- R3: With the latency strap at 1 (registered), the word from a read cycle appears on `dq_o` with `dq_oe_o` high in the cycle after the read, provided `oe_n_i` is low.
- R4: With the release strap at 0, a deselect (`cmd_i` = 2'b00, or 2'b11 which acts the same) releases the bus in the output slot that belongs to the deselect itself, even right after a read.
- R5: With the release strap at 1, a deselect slot that directly follows a read slot keeps driving that read's word for one more slot. The bus is released in the slot after it, and a second deselect slot is not driven.
- R6: A write slot (`cmd_i` = 2'b10) never drives the bus in any mode, including directly after a read in delayed-release mode.
- R7: `oe_n_i` high forces `dq_oe_o` low without any clock edge. Returning it low restores the drive within the same cycle.
- R8: Whenever `dq_oe_o` is low, `dq_o` is all zeros, which stands for the released bus.
- R9: While `rst_n_i` is low the bus is not driven. After release, the output slot before the first command counts as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Active-low synchronous reset; the straps are sampled while it is low |
| strap_pipe_i | input | 1 | Latency strap: 0 bypass, 1 registered output |
| strap_dual_i | input | 1 | Release strap: 0 immediate release, 1 one-slot delayed release |
| cmd_i | input | 2 | Command held in the input register: 00 deselect, 01 read, 10 write, 11 deselect |
| rdata_i | input | DATA_W | Array read word for this cycle's command |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dq_o | output | DATA_W | Bus data; zero when released |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach is the held final beat in delayed-release mode while registered latency is also active. Here the word on the bus was captured two edges earlier, and it has to survive a deselect that has already entered the output register. The bench resets into each of the four strap combinations. In each one it plays read bursts that end in a deselect, a second deselect, a write or a new read, so that the hold slot is entered and left by every route. A behavioural model built from the command history predicts every cycle. The output enable is also toggled in the middle of a cycle, so the asynchronous gate is seen without a clock edge.

// File: rtl/sram_oq_pkg.sv
package sram_oq_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_NOP   = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        PH_OFF   = 2'b00,
        PH_DRIVE = 2'b01,
        PH_HOLD  = 2'b10
    } phase_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_BURST = 1'b1
    } trk_e;

endpackage

// File: rtl/sram_oq_mode.sv
module sram_oq_mode (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic strap_pipe_i,
    input  logic strap_dual_i,
    output logic pipe_o,
    output logic dual_o
);
    // Straps are captured only while reset is held, then frozen (R1).
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            pipe_o <= strap_pipe_i;
            dual_o <= strap_dual_i;
        end
    end
endmodule

// File: rtl/sram_oq_stage.sv
module sram_oq_stage
    import sram_oq_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              pipe_i,
    input  logic [1:0]        cmd_i,
    input  logic [DATA_W-1:0] rdata_i,
    output cmd_e              slot_cmd_o,
    output logic [DATA_W-1:0] slot_data_o
);
    cmd_e              cmd_q;
    logic [DATA_W-1:0] data_q;

    // Optional output register; reset leaves a deselect in it (R9).
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cmd_q  <= CMD_DESEL;
            data_q <= '0;
        end else begin
            cmd_q  <= cmd_e'(cmd_i);
            data_q <= rdata_i;
        end
    end

    // Slot seen by the release logic: bypass (R2) or registered (R3).
    always_comb begin
        if (pipe_i) begin
            slot_cmd_o  = cmd_q;
            slot_data_o = data_q;
        end else begin
            slot_cmd_o  = cmd_e'(cmd_i);
            slot_data_o = rdata_i;
        end
    end
endmodule

// File: rtl/sram_oq_release.sv
module sram_oq_release
    import sram_oq_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              dual_i,
    input  cmd_e              slot_cmd_i,
    input  logic [DATA_W-1:0] slot_data_i,
    output phase_e            phase_o,
    output logic [DATA_W-1:0] word_o
);
    trk_e              st_q;
    trk_e              st_d;
    logic [DATA_W-1:0] last_q;
    logic              slot_rd;
    logic              slot_off;

    assign slot_rd  = (slot_cmd_i == CMD_READ);
    assign slot_off = (slot_cmd_i == CMD_DESEL) || (slot_cmd_i == CMD_NOP);
    assign st_d     = slot_rd ? ST_BURST : ST_QUIET;

    // State register: did the previous slot carry a read.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q   <= ST_QUIET;
            last_q <= '0;
        end else begin
            st_q <= st_d;
            if (slot_rd) begin
                last_q <= slot_data_i;
            end
        end
    end

    // Output process: phase for the current slot.
    always_comb begin
        phase_o = PH_OFF;
        unique case (st_q)
            ST_QUIET: begin
                if (slot_rd) phase_o = PH_DRIVE;
            end
            ST_BURST: begin
                if (slot_rd)                phase_o = PH_DRIVE;
                else if (slot_off && dual_i) phase_o = PH_HOLD;   // R5
            end
            default: phase_o = PH_OFF;
        endcase
        word_o = (phase_o == PH_HOLD) ? last_q : slot_data_i;
    end
endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe
    import sram_oq_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              strap_pipe_i,
    input  logic              strap_dual_i,
    input  logic [1:0]        cmd_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);
    logic              mode_pipe_q;
    logic              mode_dual_q;
    cmd_e              slot_cmd;
    logic [DATA_W-1:0] slot_data;
    phase_e            phase;
    logic [DATA_W-1:0] word;
    logic              drive;

    sram_oq_mode u_mode (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .strap_pipe_i (strap_pipe_i),
        .strap_dual_i (strap_dual_i),
        .pipe_o       (mode_pipe_q),
        .dual_o       (mode_dual_q)
    );

    sram_oq_stage #(.DATA_W(DATA_W)) u_stage (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .pipe_i      (mode_pipe_q),
        .cmd_i       (cmd_i),
        .rdata_i     (rdata_i),
        .slot_cmd_o  (slot_cmd),
        .slot_data_o (slot_data)
    );

    sram_oq_release #(.DATA_W(DATA_W)) u_rel (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .dual_i      (mode_dual_q),
        .slot_cmd_i  (slot_cmd),
        .slot_data_i (slot_data),
        .phase_o     (phase),
        .word_o      (word)
    );

    // Asynchronous enable gate (R7), reset off (R9), zero when released (R8).
    assign drive   = rst_n_i && !oe_n_i && (phase != PH_OFF);
    assign dq_oe_o = drive;
    assign dq_o    = drive ? word : '0;
endmodule

// File: rtl/sram_out_pipe_chk.sv
module sram_out_pipe_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic [1:0]        cmd_i,
    input logic [DATA_W-1:0] rdata_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              mode_pipe,
    input logic              mode_dual
);
    assert_oe_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        dq_oe_o |-> !oe_n_i);

    assert_zero_released_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !dq_oe_o |-> (dq_o == '0));

    assert_bypass_read_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!mode_pipe && cmd_i == 2'b01 && !oe_n_i) |-> (dq_oe_o && dq_o == rdata_i));

    assert_reg_read_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_pipe && $past(rst_n_i) && $past(cmd_i) == 2'b01 && !oe_n_i)
        |-> (dq_oe_o && dq_o == $past(rdata_i)));

    assert_fast_release_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!mode_dual && !mode_pipe && cmd_i == 2'b00) |-> !dq_oe_o);

    assert_hold_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_dual && !mode_pipe && $past(rst_n_i) && $past(cmd_i) == 2'b01
         && cmd_i == 2'b00 && !oe_n_i) |-> (dq_oe_o && dq_o == $past(rdata_i)));

    assert_write_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_pipe && $past(rst_n_i) && $past(cmd_i) == 2'b10) |-> !dq_oe_o);
endmodule

bind sram_out_pipe sram_out_pipe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .cmd_i     (cmd_i),
    .rdata_i   (rdata_i),
    .oe_n_i    (oe_n_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .mode_pipe (mode_pipe_q),
    .mode_dual (mode_dual_q)
);

// File: tb/sim_sram_out_pipe.sv
`timescale 1ns/1ps
module sim_sram_out_pipe;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_pipe = 1'b1;
    logic         s_dual = 1'b0;
    logic [1:0]   cmd = 2'b00;
    logic [W-1:0] rdata = '0;
    logic         oe_n = 1'b0;
    logic [W-1:0] dq;
    logic         dq_oe;

    int checks = 0;
    int fails = 0;
    bit mp, md;
    logic [1:0]   hc[$];
    logic [W-1:0] hd[$];

    always #2.5 clk = ~clk;

    sram_out_pipe #(.DATA_W(W)) u0 (
        .clk_i(clk), .rst_n_i(rst_n), .strap_pipe_i(s_pipe), .strap_dual_i(s_dual),
        .cmd_i(cmd), .rdata_i(rdata), .oe_n_i(oe_n), .dq_o(dq), .dq_oe_o(dq_oe)
    );

    task automatic check(input string tag, input logic en, input logic [W-1:0] dat);
        checks++;
        if (dq_oe !== en || dq !== dat) begin
            fails++;
            $display("FAIL %s: got oe=%b dq=%h, expected oe=%b dq=%h", tag, dq_oe, dq, en, dat);
        end
    endtask

    // Reference: slot kind/data from command history, then release rule.
    task automatic predict(output logic en, output logic [W-1:0] dat, output string tag);
        int n = hc.size() - 1;
        int s = mp ? n - 1 : n;
        logic [1:0]   sk = (s >= 0) ? hc[s] : 2'b00;
        logic [W-1:0] sd = (s >= 0) ? hd[s] : '0;
        logic [1:0]   pk = (s >= 1) ? hc[s-1] : 2'b00;
        logic [W-1:0] pd = (s >= 1) ? hd[s-1] : '0;
        bit off_kind = (sk == 2'b00 || sk == 2'b11);
        bit would = 1'b0;
        dat = '0;
        if (sk == 2'b01) begin
            would = 1'b1; dat = sd; tag = mp ? "R3" : "R2";
        end else if (off_kind && md && pk == 2'b01) begin
            would = 1'b1; dat = pd; tag = "R5";
        end else if (sk == 2'b10) begin
            tag = "R6";
        end else if (pk == 2'b01) begin
            tag = md ? "R5" : "R4";
        end else begin
            tag = (s < 0) ? "R9" : "R8";
        end
        en = would && !oe_n;
        if (would && oe_n) tag = "R7";
        if (!en) dat = '0;
    endtask

    task automatic step(input logic [1:0] c, input logic [W-1:0] d, input logic o, input bit toggle);
        logic en; logic [W-1:0] dat; string tag;
        @(negedge clk);
        cmd = c; rdata = d; oe_n = o;
        hc.push_back(c); hd.push_back(d);
        #1;
        predict(en, dat, tag);
        check(tag, en, dat);
        if (toggle && !o) begin
            oe_n = 1'b1; #0.3;
            check("R7", 1'b0, '0);
            oe_n = 1'b0; #0.3;
            check("R7", en, dat);
        end
    endtask

    task automatic do_reset(input bit p, input bit dl);
        @(negedge clk);
        rst_n = 1'b0; s_pipe = p; s_dual = dl;
        cmd = 2'b01; rdata = {W{1'b1}}; oe_n = 1'b0;
        #1 check("R9", 1'b0, '0);
        repeat (3) @(negedge clk);
        cmd = 2'b00; rdata = '0;
        @(negedge clk);
        rst_n = 1'b1;
        mp = p; md = dl;
        hc.delete(); hd.delete();
        // R1: flip straps after release; model keeps the reset-time mode
        s_pipe = !p; s_dual = !dl;
    endtask

    function automatic logic [W-1:0] word(input int m, input int i);
        return {4'(m), 32'(i * 32'h9E37_79B9 + 32'h1234)};
    endfunction

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: got running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < 4; m++) begin
            do_reset(m[0], m[1]);
            // four-beat burst then deselects (R2/R3, R4/R5)
            for (int i = 0; i < 4; i++) step(2'b01, word(m, i), 1'b0, i == 1);
            step(2'b00, word(m, 10), 1'b0, 1'b0);
            step(2'b00, word(m, 11), 1'b0, 1'b0);
            step(2'b00, word(m, 12), 1'b0, 1'b0);
            // read then write (R6)
            step(2'b01, word(m, 20), 1'b0, 1'b0);
            step(2'b10, word(m, 21), 1'b0, 1'b0);
            step(2'b00, word(m, 22), 1'b0, 1'b0);
            // read, deselect, read again
            step(2'b01, word(m, 30), 1'b0, 1'b0);
            step(2'b00, word(m, 31), 1'b0, 1'b0);
            step(2'b01, word(m, 32), 1'b0, 1'b0);
            step(2'b11, word(m, 33), 1'b0, 1'b1);
            step(2'b11, word(m, 34), 1'b0, 1'b0);
            // reads with enable high (R7)
            step(2'b01, word(m, 40), 1'b1, 1'b0);
            step(2'b01, word(m, 41), 1'b1, 1'b0);
            step(2'b00, word(m, 42), 1'b0, 1'b0);
            step(2'b10, word(m, 43), 1'b0, 1'b0);
            step(2'b10, word(m, 44), 1'b0, 1'b0);
            step(2'b00, word(m, 45), 1'b0, 1'b0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule